// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a linear, byte-addressed framebuffer. It runs two operations: a solid fill of a rectangle with one colour, and a copy of one rectangle to another place on the same surface. Source and destination of a copy may overlap. Before a command is accepted, the pixel size (1 to `MAX_BPP` bytes) and the screen width in pixels are set on configuration inputs. A row of the surface occupies pixel size times screen width bytes. The engine works through the rectangle one byte per access on a simple memory port. The memory has one cycle of read latency.

When an operation has finished, the engine appends its destination rectangle to a ring of dirty rectangles. A display path later drains that ring with a flush request. A flush either emits the stored rectangles in the order they were recorded, or discards all of them at once when the screen is to be redrawn in full anyway.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset, `busy` and `dirty_valid` are low, `cmd_ready` is high, and neither `mem_we` nor `mem_re` is asserted.
- R2: Pixel (x, y) starts at byte address bpp·x + bpp·W·y, where bpp is `cfg_bpp` and W is `cfg_width`, both sampled when the command is accepted.
- R3: A fill (`cmd_op` = 0) writes the colour's bytes least significant first, bits 7:0 at the pixel's lowest address. It restarts at byte 0 after every bpp bytes, so each pixel of the rectangle receives the low bpp bytes of the colour.
- R4: A copy (`cmd_op` = 1) leaves the destination holding the source rectangle as it was before the copy, even when the rectangles overlap vertically. Rows are moved from the bottom upward when the destination y exceeds the source y, and from the top downward otherwise. Every read is followed by the write of that byte in the next cycle.
- R5: A copy within the same rows whose destination lies to the right of its source moves each row's bytes from right to left, so an overlapping horizontal shift is also correct.
- R6: A command with height 0 or width 0 performs no memory write, yet still records its rectangle.
- R7: `busy` rises in the cycle after a command is accepted and falls after the rectangle is recorded. It stays high for 2 + n cycles for a fill and 2 + 2n cycles for a copy, where n = w·h·bpp. `cmd_ready` is low while `busy` is high, and no memory access occurs while `busy` is low.
- R8: Each finished command records (destination x, destination y, w, h). For a fill the destination fields are `cmd_dst_x`/`cmd_dst_y`.
- R9: A flush request with `flush_drop` high empties the ring without asserting `dirty_valid`.
- R10: A flush request with `flush_drop` low emits the recorded rectangles oldest first, one per `dirty_valid` cycle, until the ring is empty. Commands are held off (`cmd_ready` low) while it drains.
- R11: The ring holds `RING_DEPTH` (512) entries and its indices wrap. A record made into a full ring overwrites the oldest entry, so a later flush emits the newest 512 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_width | input | 12 | Screen width in pixels |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 1 | 0 = fill, 1 = copy |
| cmd_colour | input | 32 | Fill colour, low bytes used |
| cmd_src_x | input | 12 | Copy source x |
| cmd_src_y | input | 12 | Copy source y |
| cmd_dst_x | input | 12 | Destination x |
| cmd_dst_y | input | 12 | Destination y |
| cmd_w | input | 12 | Width in pixels |
| cmd_h | input | 12 | Height in rows |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 24 | Byte address |
| mem_re | output | 1 | Read strobe, data returned next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| flush_req | input | 1 | Request a drain of the dirty ring |
| flush_drop | input | 1 | With `flush_req`: discard instead of emitting |
| dirty_valid | output | 1 | A dirty rectangle is presented |
| dirty_x | output | 12 | Dirty rectangle x |
| dirty_y | output | 12 | Dirty rectangle y |
| dirty_w | output | 12 | Dirty rectangle width |
| dirty_h | output | 12 | Dirty rectangle height |

## Verification
The hardest state to reach from the ports is a full dirty ring that is then overwritten, because it takes more than 512 finished commands. The stimulus reaches it with 514 zero-height fills, each of which costs only a few cycles because it writes nothing, and each carries its sequence number in x. A single flush then shows whether exactly the newest 512 come out, starting from the third. The overlapping copies are compared byte for byte against a model that buffers the source before writing. A wrong row or byte order therefore shows up as a corrupted destination.

// File: rtl/rect_blit_pkg.sv
package rect_blit_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_MOVE   = 3'd2,
      ST_STORE  = 3'd3,
      ST_RECORD = 3'd4
   } blit_state_e;

   localparam logic OP_FILL = 1'b0;
   localparam logic OP_COPY = 1'b1;

endpackage

// File: rtl/rect_addr_calc.sv
// Byte address of a rectangle's top-left pixel and of its first row to visit.
module rect_addr_calc #(
   parameter int COORD_W = 12,
   parameter int ADDR_W  = 24,
   parameter int BPP_W   = 3
) (
   input  logic [COORD_W-1:0] x_i,
   input  logic [COORD_W-1:0] y_i,
   input  logic [COORD_W-1:0] h_i,
   input  logic [BPP_W-1:0]   bpp_i,
   input  logic [ADDR_W-1:0]  pitch_i,
   input  logic               from_bottom_i,
   output logic [ADDR_W-1:0]  top_addr_o,
   output logic [ADDR_W-1:0]  first_addr_o
);

   logic [ADDR_W-1:0] col_off;
   logic [ADDR_W-1:0] top_row;
   logic [ADDR_W-1:0] last_row;

   always_comb begin
      col_off      = ADDR_W'(x_i) * ADDR_W'(bpp_i);
      top_row      = ADDR_W'(y_i);
      last_row     = ADDR_W'(y_i) + ADDR_W'(h_i) - ADDR_W'(1);
      top_addr_o   = col_off + pitch_i * top_row;
      first_addr_o = from_bottom_i ? (col_off + pitch_i * last_row) : top_addr_o;
   end

endmodule

// File: rtl/rect_colour_lane.sv
// Selects the colour byte for the current position inside a pixel.
module rect_colour_lane #(
   parameter int MAX_BPP = 4,
   parameter int PH_W    = 2
) (
   input  logic [8*MAX_BPP-1:0] colour_i,
   input  logic [PH_W-1:0]      phase_i,
   output logic [7:0]           byte_o
);

   generate
      if (MAX_BPP == 1) begin : g_single
         assign byte_o = colour_i[7:0] | {8{1'b0 & phase_i[0]}};
      end else begin : g_multi
         always_comb begin
            byte_o = colour_i[7:0];
            for (int k = 1; k < MAX_BPP; k++) begin
               if (phase_i == PH_W'(k)) byte_o = colour_i[8*k +: 8];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rect_dirty_ring.sv
// Power-of-two ring of finished rectangles, drained or discarded on request.
module rect_dirty_ring #(
   parameter int DEPTH = 512,
   parameter int ENT_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [ENT_W-1:0] push_data_i,
   input  logic             flush_i,
   input  logic             drop_i,
   input  logic             idle_i,
   output logic             out_valid_o,
   output logic [ENT_W-1:0] out_data_o,
   output logic             draining_o
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = IDX_W + 1;

   logic [ENT_W-1:0] store [DEPTH];
   logic [IDX_W-1:0] wr_q;
   logic [IDX_W-1:0] rd_q;
   logic [CNT_W-1:0] fill_q;
   logic             draining_q;
   logic             full;
   logic             take_flush;

   assign full       = (fill_q == CNT_W'(DEPTH));
   assign take_flush = flush_i && idle_i && !draining_q;
   assign draining_o = draining_q;

   always_ff @(posedge clk) begin
      if (push_i) store[wr_q] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q        <= '0;
         rd_q        <= '0;
         fill_q      <= '0;
         draining_q  <= 1'b0;
         out_valid_o <= 1'b0;
         out_data_o  <= '0;
      end else begin
         out_valid_o <= 1'b0;
         if (push_i) begin
            wr_q <= wr_q + IDX_W'(1);
            if (full) rd_q   <= rd_q + IDX_W'(1);
            else      fill_q <= fill_q + CNT_W'(1);
         end else if (take_flush) begin
            if (drop_i) begin
               rd_q   <= wr_q;
               fill_q <= '0;
            end else begin
               draining_q <= 1'b1;
            end
         end else if (draining_q) begin
            if (fill_q != '0) begin
               out_data_o  <= store[rd_q];
               out_valid_o <= 1'b1;
               rd_q        <= rd_q + IDX_W'(1);
               fill_q      <= fill_q - CNT_W'(1);
               if (fill_q == CNT_W'(1)) draining_q <= 1'b0;
            end else begin
               draining_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine #(
   parameter int COORD_W    = 12,
   parameter int ADDR_W     = 24,
   parameter int MAX_BPP    = 4,
   parameter int RING_DEPTH = 512,
   localparam int BPP_W     = $clog2(MAX_BPP + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BPP_W-1:0]     cfg_bpp,
   input  logic [COORD_W-1:0]   cfg_width,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic                 cmd_op,
   input  logic [8*MAX_BPP-1:0] cmd_colour,
   input  logic [COORD_W-1:0]   cmd_src_x,
   input  logic [COORD_W-1:0]   cmd_src_y,
   input  logic [COORD_W-1:0]   cmd_dst_x,
   input  logic [COORD_W-1:0]   cmd_dst_y,
   input  logic [COORD_W-1:0]   cmd_w,
   input  logic [COORD_W-1:0]   cmd_h,
   output logic                 busy,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 mem_re,
   output logic                 mem_we,
   output logic [7:0]           mem_wdata,
   input  logic [7:0]           mem_rdata,
   input  logic                 flush_req,
   input  logic                 flush_drop,
   output logic                 dirty_valid,
   output logic [COORD_W-1:0]   dirty_x,
   output logic [COORD_W-1:0]   dirty_y,
   output logic [COORD_W-1:0]   dirty_w,
   output logic [COORD_W-1:0]   dirty_h
);
   import rect_blit_pkg::*;

   localparam int PH_W  = (MAX_BPP > 1) ? $clog2(MAX_BPP) : 1;
   localparam int RB_W  = COORD_W + BPP_W;
   localparam int ENT_W = 4 * COORD_W;

   // elaboration-time parameter checks
   if (RING_DEPTH < 2 || (RING_DEPTH & (RING_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("RING_DEPTH must be a power of two of at least 2");
   end
   if (MAX_BPP < 1 || MAX_BPP > 4) begin : g_bad_bpp
      $error("MAX_BPP must lie between 1 and 4");
   end
   if (ADDR_W < 2 * COORD_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the coordinate range");
   end

   blit_state_e state_q;

   // latched command
   logic                 op_q;
   logic [8*MAX_BPP-1:0] colour_q;
   logic [COORD_W-1:0]   sx_q, sy_q, dx_q, dy_q, w_q, h_q;
   logic [BPP_W-1:0]     bpp_q;
   logic [COORD_W-1:0]   width_q;

   // walker state
   logic [ADDR_W-1:0]    src_row_q, dst_row_q, src_ptr_q, dst_ptr_q;
   logic [ADDR_W-1:0]    pitch_q, start_off_q;
   logic [RB_W-1:0]      row_bytes_q, bytes_left_q;
   logic [COORD_W-1:0]   rows_left_q;
   logic [PH_W-1:0]      phase_q;
   logic                 up_q, back_q;

   // setup arithmetic
   logic [ADDR_W-1:0]    pitch_c;
   logic [RB_W-1:0]      row_bytes_c;
   logic                 bottom_up_c, backward_c;
   logic [ADDR_W-1:0]    src_top_c, src_first_c, dst_top_c, dst_first_c, start_off_c;
   logic [ADDR_W-1:0]    src_row_nx, dst_row_nx;
   logic [7:0]           lane_byte;
   logic                 step_c, last_phase_c, accept_c;
   logic                 ring_draining;
   logic [ENT_W-1:0]     ring_out;

   assign pitch_c     = ADDR_W'(width_q) * ADDR_W'(bpp_q);
   assign row_bytes_c = RB_W'(w_q) * RB_W'(bpp_q);
   assign bottom_up_c = (op_q == OP_COPY) && (dy_q > sy_q);

   rect_addr_calc #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .BPP_W(BPP_W)) u_src_addr (
      .x_i(sx_q), .y_i(sy_q), .h_i(h_q), .bpp_i(bpp_q), .pitch_i(pitch_c),
      .from_bottom_i(bottom_up_c), .top_addr_o(src_top_c), .first_addr_o(src_first_c)
   );

   rect_addr_calc #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .BPP_W(BPP_W)) u_dst_addr (
      .x_i(dx_q), .y_i(dy_q), .h_i(h_q), .bpp_i(bpp_q), .pitch_i(pitch_c),
      .from_bottom_i(bottom_up_c), .top_addr_o(dst_top_c), .first_addr_o(dst_first_c)
   );

   assign backward_c  = (op_q == OP_COPY) && (dst_top_c > src_top_c);
   assign start_off_c = backward_c ? ADDR_W'(row_bytes_c - RB_W'(1)) : '0;

   assign src_row_nx  = up_q ? (src_row_q - pitch_q) : (src_row_q + pitch_q);
   assign dst_row_nx  = up_q ? (dst_row_q - pitch_q) : (dst_row_q + pitch_q);

   rect_colour_lane #(.MAX_BPP(MAX_BPP), .PH_W(PH_W)) u_lane (
      .colour_i(colour_q), .phase_i(phase_q), .byte_o(lane_byte)
   );

   // port-facing control
   assign busy         = (state_q != ST_IDLE);
   assign cmd_ready    = (state_q == ST_IDLE) && !ring_draining && !flush_req;
   assign accept_c     = cmd_valid && cmd_ready;
   assign mem_re       = (state_q == ST_MOVE) && (op_q == OP_COPY);
   assign mem_we       = ((state_q == ST_MOVE) && (op_q == OP_FILL)) || (state_q == ST_STORE);
   assign mem_addr     = mem_re ? src_ptr_q : dst_ptr_q;
   assign mem_wdata    = (op_q == OP_FILL) ? lane_byte : mem_rdata;
   assign step_c       = mem_we;
   assign last_phase_c = (phase_q == PH_W'(bpp_q - BPP_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         op_q         <= OP_FILL;
         colour_q     <= '0;
         sx_q         <= '0;
         sy_q         <= '0;
         dx_q         <= '0;
         dy_q         <= '0;
         w_q          <= '0;
         h_q          <= '0;
         bpp_q        <= BPP_W'(1);
         width_q      <= '0;
         src_row_q    <= '0;
         dst_row_q    <= '0;
         src_ptr_q    <= '0;
         dst_ptr_q    <= '0;
         pitch_q      <= '0;
         start_off_q  <= '0;
         row_bytes_q  <= '0;
         bytes_left_q <= '0;
         rows_left_q  <= '0;
         phase_q      <= '0;
         up_q         <= 1'b0;
         back_q       <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept_c) begin
                  op_q     <= cmd_op;
                  colour_q <= cmd_colour;
                  sx_q     <= cmd_src_x;
                  sy_q     <= cmd_src_y;
                  dx_q     <= cmd_dst_x;
                  dy_q     <= cmd_dst_y;
                  w_q      <= cmd_w;
                  h_q      <= cmd_h;
                  bpp_q    <= cfg_bpp;
                  width_q  <= cfg_width;
                  state_q  <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (h_q == '0 || w_q == '0) begin
                  state_q <= ST_RECORD;
               end else begin
                  pitch_q      <= pitch_c;
                  row_bytes_q  <= row_bytes_c;
                  start_off_q  <= start_off_c;
                  up_q         <= bottom_up_c;
                  back_q       <= backward_c;
                  src_row_q    <= src_first_c;
                  dst_row_q    <= dst_first_c;
                  src_ptr_q    <= src_first_c + start_off_c;
                  dst_ptr_q    <= dst_first_c + start_off_c;
                  bytes_left_q <= row_bytes_c - RB_W'(1);
                  rows_left_q  <= h_q - COORD_W'(1);
                  phase_q      <= '0;
                  state_q      <= ST_MOVE;
               end
            end
            ST_MOVE: begin
               if (op_q == OP_COPY) state_q <= ST_STORE;
            end
            ST_STORE: begin
               state_q <= ST_MOVE;
            end
            ST_RECORD: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase

         if (step_c) begin
            if (bytes_left_q == '0) begin
               if (rows_left_q == '0) begin
                  state_q <= ST_RECORD;
               end else begin
                  rows_left_q  <= rows_left_q - COORD_W'(1);
                  bytes_left_q <= row_bytes_q - RB_W'(1);
                  phase_q      <= '0;
                  src_row_q    <= src_row_nx;
                  dst_row_q    <= dst_row_nx;
                  src_ptr_q    <= src_row_nx + start_off_q;
                  dst_ptr_q    <= dst_row_nx + start_off_q;
               end
            end else begin
               bytes_left_q <= bytes_left_q - RB_W'(1);
               phase_q      <= last_phase_c ? '0 : phase_q + PH_W'(1);
               if (back_q) begin
                  src_ptr_q <= src_ptr_q - ADDR_W'(1);
                  dst_ptr_q <= dst_ptr_q - ADDR_W'(1);
               end else begin
                  src_ptr_q <= src_ptr_q + ADDR_W'(1);
                  dst_ptr_q <= dst_ptr_q + ADDR_W'(1);
               end
            end
         end
      end
   end

   rect_dirty_ring #(.DEPTH(RING_DEPTH), .ENT_W(ENT_W)) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (state_q == ST_RECORD),
      .push_data_i ({dx_q, dy_q, w_q, h_q}),
      .flush_i     (flush_req),
      .drop_i      (flush_drop),
      .idle_i      (state_q == ST_IDLE),
      .out_valid_o (dirty_valid),
      .out_data_o  (ring_out),
      .draining_o  (ring_draining)
   );

   assign {dirty_x, dirty_y, dirty_w, dirty_h} = ring_out;

endmodule

// File: rtl/rect_blit_checker.sv
module rect_blit_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic mem_re,
   input logic mem_we,
   input logic flush_req,
   input logic flush_drop,
   input logic dirty_valid,
   input logic ring_draining
);

   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> busy);

   assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cmd_ready);

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_we || mem_re));

   assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (mem_we && !mem_re));

   assert_drop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && flush_drop && !busy && !ring_draining) |=> !dirty_valid);

   assert_emit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_valid |-> !busy);

endmodule

bind rect_blit_engine rect_blit_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .mem_re        (mem_re),
   .mem_we        (mem_we),
   .flush_req     (flush_req),
   .flush_drop    (flush_drop),
   .dirty_valid   (dirty_valid),
   .ring_draining (ring_draining)
);

// File: tb/sim_rect_blit_engine.sv
`timescale 1ns/1ps
module sim_rect_blit_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_bpp = 3'd1;
   logic [11:0] cfg_width = 12'd16;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_op = 1'b0;
   logic [31:0] cmd_colour = '0;
   logic [11:0] cmd_src_x = '0, cmd_src_y = '0, cmd_dst_x = '0, cmd_dst_y = '0;
   logic [11:0] cmd_w = '0, cmd_h = '0;
   logic        busy;
   logic [23:0] mem_addr;
   logic        mem_re, mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        flush_req = 1'b0, flush_drop = 1'b0;
   logic        dirty_valid;
   logic [11:0] dirty_x, dirty_y, dirty_w, dirty_h;

   always #2.5 clk = ~clk;

   rect_blit_engine u0 (
      .clk(clk), .rst_n(rst_n), .cfg_bpp(cfg_bpp), .cfg_width(cfg_width),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_colour(cmd_colour),
      .cmd_src_x(cmd_src_x), .cmd_src_y(cmd_src_y), .cmd_dst_x(cmd_dst_x), .cmd_dst_y(cmd_dst_y),
      .cmd_w(cmd_w), .cmd_h(cmd_h), .busy(busy), .mem_addr(mem_addr), .mem_re(mem_re),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .flush_req(flush_req),
      .flush_drop(flush_drop), .dirty_valid(dirty_valid), .dirty_x(dirty_x), .dirty_y(dirty_y),
      .dirty_w(dirty_w), .dirty_h(dirty_h)
   );

   // memory model: one cycle read latency
   logic [7:0] vram [0:4095];
   logic       init_req = 1'b0;
   always @(posedge clk) begin
      if (init_req) begin
         for (int i = 0; i < 4096; i++) vram[i] <= 8'(i * 7 + 3);
      end else if (mem_we) begin
         vram[mem_addr[11:0]] <= mem_wdata;
      end
      if (mem_re) mem_rdata <= vram[mem_addr[11:0]];
   end

   // dirty rectangle collector
   int          got_n = 0;
   logic [11:0] got_x [0:1023];
   logic [11:0] got_y [0:1023];
   logic [11:0] got_w [0:1023];
   logic [11:0] got_h [0:1023];
   always @(negedge clk) begin
      if (dirty_valid && got_n < 1024) begin
         got_x[got_n] = dirty_x;
         got_y[got_n] = dirty_y;
         got_w[got_n] = dirty_w;
         got_h[got_n] = dirty_h;
         got_n = got_n + 1;
      end
   end

   // bench-side expectations
   logic [7:0]  ref_mem [0:4095];
   logic [7:0]  tmp_buf [0:4095];
   int          exp_n = 0;
   int          exp_x [0:63];
   int          exp_y [0:63];
   int          exp_w [0:63];
   int          exp_h [0:63];
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic init_both();
      @(negedge clk);
      init_req = 1'b1;
      @(negedge clk);
      init_req = 1'b0;
      for (int i = 0; i < 4096; i++) ref_mem[i] = 8'(i * 7 + 3);
   endtask

   task automatic cmp_mem(input string req, input string what);
      int bad;
      int first;
      bad = 0;
      first = 0;
      for (int i = 0; i < 4096; i++) begin
         if (vram[i] !== ref_mem[i]) begin
            if (bad == 0) first = i;
            bad++;
         end
      end
      if (bad == 0) chk(1'b1, req, what, 0, 0);
      else chk(1'b0, req, $sformatf("%s byte %0d", what, first), vram[first], ref_mem[first]);
   endtask

   function automatic int paddr(input int x, input int y);
      return int'(cfg_bpp) * x + int'(cfg_bpp) * int'(cfg_width) * y;
   endfunction

   task automatic ref_fill(input logic [31:0] col, input int x, input int y, input int w, input int h);
      int b;
      b = int'(cfg_bpp);
      for (int r = 0; r < h; r++)
         for (int c = 0; c < w * b; c++)
            ref_mem[paddr(x, y + r) + c] = col[8 * (c % b) +: 8];
   endtask

   task automatic ref_copy(input int sx, input int sy, input int dx, input int dy,
                           input int w, input int h);
      int b;
      b = int'(cfg_bpp);
      for (int r = 0; r < h; r++)
         for (int c = 0; c < w * b; c++)
            tmp_buf[r * w * b + c] = ref_mem[paddr(sx, sy + r) + c];
      for (int r = 0; r < h; r++)
         for (int c = 0; c < w * b; c++)
            ref_mem[paddr(dx, dy + r) + c] = tmp_buf[r * w * b + c];
   endtask

   // issue one command, wait for it to finish; returns the busy cycle count
   task automatic do_cmd(input logic op, input logic [31:0] col, input int sx, input int sy,
                         input int dx, input int dy, input int w, input int h,
                         input bit track, output int bcyc, output int ready_bad);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_op     = op;
      cmd_colour = col;
      cmd_src_x  = 12'(sx);
      cmd_src_y  = 12'(sy);
      cmd_dst_x  = 12'(dx);
      cmd_dst_y  = 12'(dy);
      cmd_w      = 12'(w);
      cmd_h      = 12'(h);
      cmd_valid  = 1'b1;
      @(negedge clk);
      cmd_valid  = 1'b0;
      bcyc = 0;
      ready_bad = 0;
      while (busy) begin
         bcyc++;
         if (cmd_ready) ready_bad++;
         @(negedge clk);
      end
      if (op == 1'b0) ref_fill(col, dx, dy, w, h);
      else ref_copy(sx, sy, dx, dy, w, h);
      if (track && exp_n < 64) begin
         exp_x[exp_n] = dx;
         exp_y[exp_n] = dy;
         exp_w[exp_n] = w;
         exp_h[exp_n] = h;
         exp_n++;
      end
   endtask

   task automatic do_flush(input bit drop);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      flush_req  = 1'b1;
      flush_drop = drop;
      @(negedge clk);
      flush_req  = 1'b0;
      flush_drop = 1'b0;
      repeat (2) @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk(cmd_ready === 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
      chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
      chk(dirty_valid === 1'b0, "R1", "dirty_valid after reset", dirty_valid, 0);
      chk((mem_we | mem_re) === 1'b0, "R1", "memory strobes after reset", mem_we | mem_re, 0);
   endtask

   task automatic t_fill_sizes();
      int bc, rb;
      init_both();
      cfg_width = 12'd16;
      for (int b = 1; b <= 4; b++) begin
         cfg_bpp = 3'(b);
         do_cmd(1'b0, 32'hA1B2C3D4 + 32'(b), 0, 0, 2 + b, b, 3, 2, 1'b1, bc, rb);
         cmp_mem("R3", $sformatf("fill bpp=%0d", b));
         chk(bc == 3 * 2 * b + 2, "R7", $sformatf("fill busy cycles bpp=%0d", b), bc, 3 * 2 * b + 2);
         chk(rb == 0, "R7", "cmd_ready while busy", rb, 0);
      end
      // R2: a single pixel lands at bpp*x + bpp*W*y
      cfg_bpp = 3'd3;
      cfg_width = 12'd10;
      do_cmd(1'b0, 32'h00EEDDCC, 0, 0, 7, 5, 1, 1, 1'b1, bc, rb);
      chk(vram[3 * 7 + 30 * 5] === 8'hCC && vram[3 * 7 + 30 * 5 + 2] === 8'hEE, "R2",
          "pixel address for (7,5)", vram[3 * 7 + 30 * 5], 8'hCC);
      cmp_mem("R2", "single pixel fill");
   endtask

   task automatic t_copies();
      int bc, rb;
      init_both();
      cfg_width = 12'd16;
      cfg_bpp = 3'd2;
      do_cmd(1'b1, 0, 2, 1, 3, 2, 4, 3, 1'b1, bc, rb);
      cmp_mem("R4", "overlapping copy downward");
      chk(bc == 2 * 4 * 3 * 2 + 2, "R7", "copy busy cycles", bc, 2 * 4 * 3 * 2 + 2);
      do_cmd(1'b1, 0, 2, 4, 1, 2, 4, 3, 1'b1, bc, rb);
      cmp_mem("R4", "overlapping copy upward");
      cfg_bpp = 3'd1;
      do_cmd(1'b1, 0, 2, 6, 4, 6, 6, 1, 1'b1, bc, rb);
      cmp_mem("R5", "same-row copy to the right");
      do_cmd(1'b1, 0, 5, 7, 3, 7, 6, 2, 1'b1, bc, rb);
      cmp_mem("R5", "same-row copy to the left");
   endtask

   task automatic t_empty();
      int bc, rb;
      cfg_bpp = 3'd4;
      do_cmd(1'b0, 32'hFFFFFFFF, 0, 0, 1, 1, 4, 0, 1'b1, bc, rb);
      cmp_mem("R6", "zero-height fill writes nothing");
      chk(bc == 2, "R6", "zero-height busy cycles", bc, 2);
      do_cmd(1'b1, 0, 0, 0, 2, 3, 0, 3, 1'b1, bc, rb);
      cmp_mem("R6", "zero-width copy writes nothing");
   endtask

   task automatic t_flush_order();
      int base, bad;
      base = got_n;
      do_flush(1'b0);
      chk(got_n - base == exp_n, "R10", "entries emitted", got_n - base, exp_n);
      bad = 0;
      for (int i = 0; i < exp_n && base + i < got_n; i++) begin
         if (int'(got_x[base + i]) != exp_x[i] || int'(got_y[base + i]) != exp_y[i] ||
             int'(got_w[base + i]) != exp_w[i] || int'(got_h[base + i]) != exp_h[i]) begin
            if (bad == 0)
               chk(1'b0, "R8", $sformatf("entry %0d x", i), got_x[base + i], exp_x[i]);
            bad++;
         end
      end
      if (bad == 0) chk(1'b1, "R8", "entry contents", 0, 0);
      exp_n = 0;
      base = got_n;
      do_flush(1'b0);
      chk(got_n == base, "R10", "second flush on empty ring", got_n - base, 0);
   endtask

   task automatic t_drop();
      int bc, rb, base;
      cfg_bpp = 3'd1;
      do_cmd(1'b0, 32'h5A, 0, 0, 1, 9, 2, 1, 1'b1, bc, rb);
      do_cmd(1'b0, 32'h6B, 0, 0, 4, 9, 2, 1, 1'b1, bc, rb);
      base = got_n;
      do_flush(1'b1);
      chk(got_n == base, "R9", "drop emits nothing", got_n - base, 0);
      do_flush(1'b0);
      chk(got_n == base, "R9", "ring empty after drop", got_n - base, 0);
      exp_n = 0;
   endtask

   task automatic t_wrap();
      int bc, rb, base;
      cfg_bpp = 3'd1;
      for (int i = 0; i < 514; i++) do_cmd(1'b0, 0, 0, 0, i, 1, 2, 0, 1'b0, bc, rb);
      base = got_n;
      do_flush(1'b0);
      chk(got_n - base == 512, "R11", "entries after overfill", got_n - base, 512);
      chk(got_x[base] == 12'd2, "R11", "oldest surviving entry", got_x[base], 2);
      chk(got_x[base + 511] == 12'd513, "R11", "newest entry", got_x[base + 511], 513);
      chk(got_x[base + 300] == 12'd302, "R11", "order across the wrap", got_x[base + 300], 302);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill_sizes();
      t_copies();
      t_empty();
      t_flush_order();
      t_drop();
      t_wrap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule